// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Register Block

This block collects up to 32 external interrupt request lines and records them in two places: a system-wide pending vector with one bit per source, and a pending word belonging to one selectable CPU, where each source lands on the bit of its priority level. Software reaches the block through a simple register bus. It has one system window and sixteen CPU windows, chosen by a region-select input and by the page bits of the address. Writes either set or clear bits rather than overwrite them, so several agents can update shared state without a read-modify-write.

The system window holds a mask vector. Writing to one word clears mask bits, which enables those sources. Writing to another word sets mask bits and also discards any pending state for those sources. A fixed set of mask bit positions can never be written. A CPU window lets software raise or drop its own soft-interrupt bits in the upper part of that CPU's pending word. The system pending and mask vectors leave the block continuously, for a separate level resolver. Priority resolution and the signalling of CPUs are done elsewhere.

Source lines are sampled on every clock. Only their edges change state: a rising edge records the source and a falling edge withdraws it. Reads return data one clock after the request.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the system pending vector is 0, the system mask is 0x004DFF80, the target CPU is 0 and every CPU pending word is 0.
- R2: A rising edge on source i whose level L is nonzero sets system pending bit i and bit L of the current target CPU's pending word, visible one clock after the first sampling edge. The levels of sources 0..31, in order, are 2,3,5,7,9,11,0,14,3,5,7,9,11,13,12,12,6,0,4,10,8,0,11,0,0,0,0,0,15,0,0,0.
- R3: A falling edge on a source with a nonzero level clears its system pending bit and its level bit in the current target CPU's word. If in one cycle one source of a level falls and another of the same level rises, the level bit ends set.
- R4: Sources whose level is 0 (bits 6, 17, 21, 23 to 27, 29, 30, 31) never change any state.
- R5: In a CPU window (region select low), address bits [15:12] pick the CPU and bits [3:2] pick the word. Word 0 reads the pending word. A write to word 1 clears, and a write to word 2 sets, the pending bits that are set in the write data, restricted to bits 31:17.
- R6: In the system window (region select high, word = address bits [4:2]), a write to word 2 clears mask bits. A write to word 3 sets mask bits and clears the same system pending bits. For both, data bits set in 0x7FB2007F are forced to zero first.
- R7: A system word 4 write stores the low 4 data bits as the target CPU, and a read of word 4 returns it zero-extended.
- R8: System word 0 reads the pending vector with bit 31 forced to 0, and system word 1 reads the mask. The region select alone decides between the system window and CPU 0 at the same address.
- R9: Reads of unmapped words (system 2, 3, 5, 6, 7 and CPU word 3) return 0. Writes to system words 0, 1, 5, 6, 7 and to CPU words 0 and 3 change nothing.
- R10: Read data appears one clock after a read request and holds its value until the next read.
- R11: When a source edge and a register write fall in the same cycle, the source update is applied first, using the target CPU from before the write, and the write is applied after it.
- R12: A source held high sets pending only once. After a mask-set write clears it, pending stays clear, even after an unmask, until the source falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sys | input | 1 | 1 = system window, 0 = CPU windows |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| src_lvl | input | 32 | Interrupt source lines, level sampled |
| sys_pend_o | output | 32 | System pending vector |
| sys_mask_o | output | 32 | System mask vector |

## Verification
Some properties are checked on every cycle: level-0 sources and bit 31 never show as pending, the locked mask bits stay at zero, a mask-set write leaves its bits masked and not pending, and read data holds between reads. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers the source-to-level map landing in the right CPU word, the effect of changing the target, the set and clear paths for soft bits, the ignored and aliased addresses, and the ordering of a source edge and a write in the same cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned SRC_N  = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LVL_W  = 4;

    // mask positions that no write may touch
    localparam logic [DATA_W-1:0] SYS_LOCKED_BITS = 32'h7FB2_007F;
    // mask value after reset
    localparam logic [DATA_W-1:0] SYS_MASK_RST    = ~32'hFFB2_007F;
    // soft-interrupt bits reachable from a CPU window
    localparam logic [DATA_W-1:0] SOFT_BITS       = 32'hFFFE_0000;
    // system pending read keeps all but the top bit
    localparam logic [DATA_W-1:0] SYS_RD_KEEP     = 32'h7FFF_FFFF;

    typedef enum logic [2:0] {
        SYS_W_PEND    = 3'd0,
        SYS_W_MASK    = 3'd1,
        SYS_W_UNMASK  = 3'd2,
        SYS_W_MASKSET = 3'd3,
        SYS_W_TARGET  = 3'd4,
        SYS_W_RSV5    = 3'd5,
        SYS_W_RSV6    = 3'd6,
        SYS_W_RSV7    = 3'd7
    } sys_word_e;

    typedef enum logic [1:0] {
        CPU_W_PEND = 2'd0,
        CPU_W_CLR  = 2'd1,
        CPU_W_SET  = 2'd2,
        CPU_W_RSV3 = 2'd3
    } cpu_word_e;

    // priority level reached by each source line; 0 means unused
    function automatic logic [LVL_W-1:0] src_level(input int unsigned idx);
        logic [LVL_W-1:0] lv;
        case (idx)
            0:       lv = 4'd2;
            1:       lv = 4'd3;
            2:       lv = 4'd5;
            3:       lv = 4'd7;
            4:       lv = 4'd9;
            5:       lv = 4'd11;
            7:       lv = 4'd14;
            8:       lv = 4'd3;
            9:       lv = 4'd5;
            10:      lv = 4'd7;
            11:      lv = 4'd9;
            12:      lv = 4'd11;
            13:      lv = 4'd13;
            14:      lv = 4'd12;
            15:      lv = 4'd12;
            16:      lv = 4'd6;
            18:      lv = 4'd4;
            19:      lv = 4'd10;
            20:      lv = 4'd8;
            22:      lv = 4'd11;
            28:      lv = 4'd15;
            default: lv = 4'd0;
        endcase
        return lv;
    endfunction

    // sources that carry no level
    function automatic logic [SRC_N-1:0] dead_sources();
        logic [SRC_N-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < SRC_N; i++) begin
            m[i] = (src_level(i) == '0);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_route_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned PAGE_LSB = 12,
    parameter int unsigned NCPU     = 16,
    localparam int unsigned CPU_W   = $clog2(NCPU)
) (
    input  logic             bus_vld,
    input  logic             bus_wr,
    input  logic             bus_sys,
    input  logic [AW-1:0]    bus_addr,
    output logic             unmask_we_o,
    output logic             maskset_we_o,
    output logic             target_we_o,
    output logic             soft_clr_we_o,
    output logic             soft_set_we_o,
    output logic [CPU_W-1:0] cpu_sel_o,
    output logic             rd_en_o,
    output sys_word_e        sys_word_o,
    output cpu_word_e        cpu_word_o
);

    logic wr_sys;
    logic wr_cpu;
    logic unused_addr_bits;

    assign sys_word_o = sys_word_e'(bus_addr[4:2]);
    assign cpu_word_o = cpu_word_e'(bus_addr[3:2]);
    assign cpu_sel_o  = bus_addr[PAGE_LSB +: CPU_W];

    assign wr_sys = bus_vld && bus_wr && bus_sys;
    assign wr_cpu = bus_vld && bus_wr && !bus_sys;

    always_comb begin
        unmask_we_o   = 1'b0;
        maskset_we_o  = 1'b0;
        target_we_o   = 1'b0;
        soft_clr_we_o = 1'b0;
        soft_set_we_o = 1'b0;
        if (wr_sys) begin
            case (sys_word_o)
                SYS_W_UNMASK:  unmask_we_o  = 1'b1;
                SYS_W_MASKSET: maskset_we_o = 1'b1;
                SYS_W_TARGET:  target_we_o  = 1'b1;
                default:       ;
            endcase
        end
        if (wr_cpu) begin
            case (cpu_word_o)
                CPU_W_CLR: soft_clr_we_o = 1'b1;
                CPU_W_SET: soft_set_we_o = 1'b1;
                default:   ;
            endcase
        end
    end

    assign rd_en_o = bus_vld && !bus_wr;

    assign unused_addr_bits = ^bus_addr;

endmodule

// File: rtl/irq_src_tracker.sv
module irq_src_tracker
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC = SRC_N,
    parameter int unsigned DW   = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    output logic [NSRC-1:0] rise_o,
    output logic [NSRC-1:0] fall_o,
    output logic [DW-1:0]   lvl_set_o,
    output logic [DW-1:0]   lvl_clr_o
);

    typedef struct packed {
        logic [NSRC-1:0] seen;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        rise_o     = '0;
        fall_o     = '0;
        lvl_set_o  = '0;
        lvl_clr_o  = '0;
        for (int unsigned i = 0; i < NSRC; i++) begin
            if (src_level(i) != '0) begin
                rise_o[i] = src_i[i] && !trk_q.seen[i];
                fall_o[i] = !src_i[i] && trk_q.seen[i];
                if (rise_o[i]) lvl_set_o = lvl_set_o | (DW'(1) << src_level(i));
                if (fall_o[i]) lvl_clr_o = lvl_clr_o | (DW'(1) << src_level(i));
            end
        end
        trk_d.seen = src_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/irq_sys_bank.sv
module irq_sys_bank
    import irq_route_pkg::*;
#(
    parameter int unsigned NSRC   = SRC_N,
    parameter int unsigned NCPU   = 16,
    localparam int unsigned CPU_W = $clog2(NCPU)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  rise_i,
    input  logic [NSRC-1:0]  fall_i,
    input  logic             unmask_we_i,
    input  logic             maskset_we_i,
    input  logic             target_we_i,
    input  logic [NSRC-1:0]  wdata_i,
    output logic [NSRC-1:0]  pend_o,
    output logic [NSRC-1:0]  mask_o,
    output logic [CPU_W-1:0] target_o
);

    typedef struct packed {
        logic [NSRC-1:0]  pend;
        logic [NSRC-1:0]  mask;
        logic [CPU_W-1:0] target;
    } sys_t;

    sys_t sys_d, sys_q;
    logic [NSRC-1:0] wr_bits;

    assign wr_bits = wdata_i & ~SYS_LOCKED_BITS[NSRC-1:0];

    always_comb begin
        sys_d = sys_q;
        // source edges first
        sys_d.pend = (sys_q.pend & ~fall_i) | rise_i;
        // register writes on top
        if (unmask_we_i) begin
            sys_d.mask = sys_q.mask & ~wr_bits;
        end
        if (maskset_we_i) begin
            sys_d.mask = sys_q.mask | wr_bits;
            sys_d.pend = sys_d.pend & ~wr_bits;
        end
        if (target_we_i) begin
            sys_d.target = wdata_i[CPU_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_q.pend   <= '0;
            sys_q.mask   <= SYS_MASK_RST[NSRC-1:0];
            sys_q.target <= '0;
        end else begin
            sys_q <= sys_d;
        end
    end

    assign pend_o   = sys_q.pend;
    assign mask_o   = sys_q.mask;
    assign target_o = sys_q.target;

endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
    import irq_route_pkg::*;
#(
    parameter int unsigned NCPU   = 16,
    parameter int unsigned DW     = DATA_W,
    localparam int unsigned CPU_W = $clog2(NCPU)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CPU_W-1:0] target_i,
    input  logic [DW-1:0]    lvl_set_i,
    input  logic [DW-1:0]    lvl_clr_i,
    input  logic             soft_clr_we_i,
    input  logic             soft_set_we_i,
    input  logic [CPU_W-1:0] soft_cpu_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [CPU_W-1:0] rd_cpu_i,
    output logic [DW-1:0]    rd_pend_o
);

    typedef struct packed {
        logic [NCPU-1:0][DW-1:0] pend;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [DW-1:0] next_word [NCPU];
    logic [DW-1:0] soft_bits;

    assign soft_bits = wdata_i & SOFT_BITS[DW-1:0];

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic          is_target;
        logic          is_soft;
        logic [DW-1:0] hw_word;
        assign is_target = (target_i == CPU_W'(c));
        assign is_soft   = (soft_cpu_i == CPU_W'(c));
        assign hw_word   = is_target ? ((bank_q.pend[c] & ~lvl_clr_i) | lvl_set_i)
                                     : bank_q.pend[c];
        always_comb begin
            next_word[c] = hw_word;
            if (is_soft && soft_clr_we_i) next_word[c] = hw_word & ~soft_bits;
            if (is_soft && soft_set_we_i) next_word[c] = hw_word | soft_bits;
        end
    end

    always_comb begin
        bank_d = bank_q;
        for (int unsigned c = 0; c < NCPU; c++) begin
            bank_d.pend[c] = next_word[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rd_pend_o = bank_q.pend[rd_cpu_i];

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned PAGE_LSB = 12,
    parameter int unsigned NCPU     = 16,
    localparam int unsigned CPU_W   = $clog2(NCPU),
    localparam int unsigned DW      = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_vld,
    input  logic          bus_wr,
    input  logic          bus_sys,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] src_lvl,
    output logic [DW-1:0] sys_pend_o,
    output logic [DW-1:0] sys_mask_o
);

    logic             unmask_we, maskset_we, target_we;
    logic             soft_clr_we, soft_set_we;
    logic [CPU_W-1:0] cpu_sel;
    logic             rd_en;
    sys_word_e        sys_word;
    cpu_word_e        cpu_word;

    logic [DW-1:0]    rise, fall, lvl_set, lvl_clr;
    logic [CPU_W-1:0] target;
    logic [DW-1:0]    cpu_word_val;

    irq_bus_decode #(.AW(AW), .PAGE_LSB(PAGE_LSB), .NCPU(NCPU)) u_dec (
        .bus_vld      (bus_vld),
        .bus_wr       (bus_wr),
        .bus_sys      (bus_sys),
        .bus_addr     (bus_addr),
        .unmask_we_o  (unmask_we),
        .maskset_we_o (maskset_we),
        .target_we_o  (target_we),
        .soft_clr_we_o(soft_clr_we),
        .soft_set_we_o(soft_set_we),
        .cpu_sel_o    (cpu_sel),
        .rd_en_o      (rd_en),
        .sys_word_o   (sys_word),
        .cpu_word_o   (cpu_word)
    );

    irq_src_tracker #(.NSRC(DW), .DW(DW)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_lvl),
        .rise_o   (rise),
        .fall_o   (fall),
        .lvl_set_o(lvl_set),
        .lvl_clr_o(lvl_clr)
    );

    irq_sys_bank #(.NSRC(DW), .NCPU(NCPU)) u_sys (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .fall_i      (fall),
        .unmask_we_i (unmask_we),
        .maskset_we_i(maskset_we),
        .target_we_i (target_we),
        .wdata_i     (bus_wdata),
        .pend_o      (sys_pend_o),
        .mask_o      (sys_mask_o),
        .target_o    (target)
    );

    irq_cpu_bank #(.NCPU(NCPU), .DW(DW)) u_cpu (
        .clk          (clk),
        .rst_n        (rst_n),
        .target_i     (target),
        .lvl_set_i    (lvl_set),
        .lvl_clr_i    (lvl_clr),
        .soft_clr_we_i(soft_clr_we),
        .soft_set_we_i(soft_set_we),
        .soft_cpu_i   (cpu_sel),
        .wdata_i      (bus_wdata),
        .rd_cpu_i     (cpu_sel),
        .rd_pend_o    (cpu_word_val)
    );

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            if (bus_sys) begin
                case (sys_word)
                    SYS_W_PEND:   rd_d.rdata = sys_pend_o & SYS_RD_KEEP;
                    SYS_W_MASK:   rd_d.rdata = sys_mask_o;
                    SYS_W_TARGET: rd_d.rdata = DW'(target);
                    default:      rd_d.rdata = '0;
                endcase
            end else begin
                rd_d.rdata = (cpu_word == CPU_W_PEND) ? cpu_word_val : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
    import irq_route_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_vld,
    input logic          bus_wr,
    input logic          bus_sys,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic [31:0]   sys_pend_o,
    input logic [31:0]   sys_mask_o
);

    localparam logic [31:0] DEAD = dead_sources();

    logic        maskset_req;
    logic [31:0] maskset_bits;
    logic        unused_chk;

    assign maskset_req  = bus_vld && bus_wr && bus_sys && (bus_addr[4:2] == 3'd3);
    assign maskset_bits = bus_wdata & ~SYS_LOCKED_BITS;
    assign unused_chk   = ^bus_addr;

    // R4
    dead_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_pend_o & DEAD) == 32'h0);

    // R8
    top_pend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_pend_o[31] == 1'b0);

    // R6
    locked_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_mask_o & SYS_LOCKED_BITS) == 32'h0);

    // R6
    maskset_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        maskset_req |=> (((sys_mask_o & $past(maskset_bits)) == $past(maskset_bits))
                         && ((sys_pend_o & $past(maskset_bits)) == 32'h0)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_vld && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_vld   (bus_vld),
    .bus_wr    (bus_wr),
    .bus_sys   (bus_sys),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sys_pend_o(sys_pend_o),
    .sys_mask_o(sys_mask_o)
);

// File: tb/irq_route_ctrl_bench.sv
`timescale 1ns/1ps
module irq_route_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_vld = 1'b0, bus_wr = 1'b0, bus_sys = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_lvl = '0;
    logic [31:0] sys_pend_o, sys_mask_o;

    always #10 clk = ~clk;

    irq_route_ctrl u_irq_route_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_sys(bus_sys),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_lvl(src_lvl), .sys_pend_o(sys_pend_o), .sys_mask_o(sys_mask_o)
    );

    // reference state
    int          lvl_tab [32] = '{2,3,5,7,9,11,0,14,3,5,7,9,11,13,12,12,
                                  6,0,4,10,8,0,11,0,0,0,0,0,15,0,0,0};
    logic [31:0] m_pend, m_mask, m_rd, m_prev;
    logic [3:0]  m_tgt;
    logic [31:0] m_cpu [16];

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    task automatic model_reset();
        m_pend = '0;
        m_mask = 32'h004D_FF80;
        m_rd   = '0;
        m_prev = '0;
        m_tgt  = '0;
        foreach (m_cpu[k]) m_cpu[k] = '0;
    endtask

    task automatic model_step();
        logic [31:0] bits;
        int          c;
        if (bus_vld && !bus_wr) begin
            if (bus_sys) begin
                case (bus_addr[4:2])
                    3'd0:    m_rd = m_pend & 32'h7FFF_FFFF;
                    3'd1:    m_rd = m_mask;
                    3'd4:    m_rd = {28'h0, m_tgt};
                    default: m_rd = '0;
                endcase
            end else begin
                c = int'(bus_addr[15:12]);
                m_rd = (bus_addr[3:2] == 2'd0) ? m_cpu[c] : 32'h0;
            end
        end
        for (int i = 0; i < 32; i++) begin
            if (lvl_tab[i] != 0 && m_prev[i] && !src_lvl[i]) begin
                m_pend[i] = 1'b0;
                m_cpu[m_tgt][lvl_tab[i]] = 1'b0;
            end
        end
        for (int i = 0; i < 32; i++) begin
            if (lvl_tab[i] != 0 && !m_prev[i] && src_lvl[i]) begin
                m_pend[i] = 1'b1;
                m_cpu[m_tgt][lvl_tab[i]] = 1'b1;
            end
        end
        m_prev = src_lvl;
        if (bus_vld && bus_wr) begin
            if (bus_sys) begin
                bits = bus_wdata & ~32'h7FB2_007F;
                case (bus_addr[4:2])
                    3'd2: m_mask = m_mask & ~bits;
                    3'd3: begin m_mask = m_mask | bits; m_pend = m_pend & ~bits; end
                    3'd4: m_tgt = bus_wdata[3:0];
                    default: ;
                endcase
            end else begin
                c = int'(bus_addr[15:12]);
                bits = bus_wdata & 32'hFFFE_0000;
                case (bus_addr[3:2])
                    2'd1: m_cpu[c] = m_cpu[c] & ~bits;
                    2'd2: m_cpu[c] = m_cpu[c] | bits;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%08h expected=%08h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // one clock: drive, let the edge pass, update model, compare mid-cycle
    task automatic cyc(input logic v, input logic w, input logic s,
                       input logic [15:0] a, input logic [31:0] d);
        bus_vld = v; bus_wr = w; bus_sys = s; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp("sys_pend", sys_pend_o, m_pend);
        cmp("sys_mask", sys_mask_o, m_mask);
        cmp("rdata", bus_rdata, m_rd);
        bus_vld = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 1'b0, 16'h0, 32'h0);
    endtask
    task automatic sys_wr(input logic [15:0] a, input logic [31:0] d); cyc(1'b1, 1'b1, 1'b1, a, d); endtask
    task automatic sys_rd(input logic [15:0] a);                       cyc(1'b1, 1'b0, 1'b1, a, 32'h0); endtask
    task automatic cpu_wr(input logic [15:0] a, input logic [31:0] d); cyc(1'b1, 1'b1, 1'b0, a, d); endtask
    task automatic cpu_rd(input logic [15:0] a);                       cyc(1'b1, 1'b0, 1'b0, a, 32'h0); endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog all actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        cur_req = "R1";
        sys_rd(16'h0004);
        sys_rd(16'h0010);
        sys_rd(16'h0000);
        for (int c = 0; c < 16; c++) cpu_rd(16'(c << 12));

        // R2: rising sources reach target 0, then target 5
        cur_req = "R2";
        src_lvl = 32'h0000_0001; idle(1);
        cpu_rd(16'h0000);
        sys_wr(16'h0010, 32'h5);
        src_lvl = 32'h0010_0081; idle(1);
        cpu_rd(16'h5000);
        cpu_rd(16'h0000);
        src_lvl = 32'h1019_FF81; idle(2);
        cpu_rd(16'h5000);

        // R3: falls clear level bits; shared-level fall + rise keeps the bit
        cur_req = "R3";
        src_lvl = 32'h1019_FF01; idle(1);
        cpu_rd(16'h5000);
        src_lvl = 32'h1019_7F01; idle(1);
        src_lvl = 32'h1019_BF01; idle(1);
        cpu_rd(16'h5000);
        src_lvl = 32'h0; idle(1);
        cpu_rd(16'h5000);

        // R4: dead sources leave everything alone
        cur_req = "R4";
        src_lvl = 32'hEFA2_0040; idle(2);
        sys_rd(16'h0000);
        cpu_rd(16'h5000);
        src_lvl = 32'h0; idle(1);

        // R5: soft bits set/clear in a CPU window
        cur_req = "R5";
        cpu_wr(16'h3008, 32'hFFFF_FFFF);
        cpu_rd(16'h3000);
        cpu_wr(16'h3004, 32'h0006_0000);
        cpu_rd(16'h3000);
        cpu_rd(16'h3010);
        cpu_rd(16'h2000);

        // R6: mask clear/set with locked bits and pending clear
        cur_req = "R6";
        sys_wr(16'h0008, 32'hFFFF_FFFF);
        sys_rd(16'h0004);
        src_lvl = 32'h0000_8004; idle(1);
        sys_wr(16'h000C, 32'hFFFF_FFFF);
        sys_rd(16'h0004);
        sys_rd(16'h0000);

        // R7: target register width
        cur_req = "R7";
        sys_wr(16'h0010, 32'h1234_567A);
        sys_rd(16'h0010);

        // R8: pending read and region select
        cur_req = "R8";
        src_lvl = 32'h0000_0000; idle(1);
        src_lvl = 32'h0000_0201; idle(1);
        sys_rd(16'h0000);
        cpu_rd(16'h0000);
        cpu_rd(16'hA000);

        // R9: unmapped reads and ignored writes
        cur_req = "R9";
        sys_rd(16'h0008); sys_rd(16'h000C);
        sys_rd(16'h0014); sys_rd(16'h0018); sys_rd(16'h001C);
        cpu_rd(16'hA00C);
        sys_wr(16'h0000, 32'hFFFF_FFFF);
        sys_wr(16'h0004, 32'h0);
        sys_wr(16'h0014, 32'hFFFF_FFFF);
        cpu_wr(16'hA000, 32'h0);
        cpu_wr(16'hA00C, 32'hFFFF_FFFF);
        sys_rd(16'h0000);
        cpu_rd(16'hA000);

        // R10: read data holds across idle cycles
        cur_req = "R10";
        sys_rd(16'h0004);
        idle(4);

        // R11: same-cycle source edge and writes
        cur_req = "R11";
        sys_wr(16'h0008, 32'hFFFF_FFFF);
        src_lvl = 32'h0000_8201;
        sys_wr(16'h000C, 32'h0000_8000);
        sys_rd(16'h0000);
        src_lvl = 32'h1000_8201;
        sys_wr(16'h0010, 32'h7);
        cpu_rd(16'hA000);
        cpu_rd(16'h7000);

        // R12: held source does not re-pend
        cur_req = "R12";
        sys_wr(16'h0008, 32'hFFFF_FFFF);
        idle(3);
        sys_rd(16'h0000);
        src_lvl = 32'h1000_0201; idle(1);
        src_lvl = 32'h1000_8201; idle(1);
        sys_rd(16'h0000);

        // R2: mixed traffic
        cur_req = "R2";
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[0]) src_lvl = src_lvl ^ (32'h1 << r[12:8]);
            case (r[4:2])
                3'd0: sys_wr({11'h0, r[15:13], 2'b00}, $urandom);
                3'd1: sys_rd({11'h0, r[15:13], 2'b00});
                3'd2: cpu_wr({r[19:16], 8'h0, r[21:20], 2'b00}, $urandom);
                3'd3: cpu_rd({r[19:16], 8'h0, r[21:20], 2'b00});
                default: idle(1);
            endcase
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule